// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block sequences the start of each conversion for a successive-approximation ADC. Software reaches it through a single 8-bit control register. The register selects the event that launches a conversion: a software write, one of four timer overflow pulses, or a rising edge on an external convert-start pin. It also chooses how the sampling phase is handled. In continuous mode the input is tracked whenever the converter is enabled and idle. In low-power mode tracking happens only in a timed window just before each conversion, or only while the external pin is held low.

The SAR core is treated as a fixed number of SAR clock periods. The SAR clock comes from a programmable divider of the system clock. The block drives a track level and a convert level toward that core. It keeps a busy indication and two sticky flags: one for conversion complete and one for window match. The window comparator lives elsewhere and reports each match as a one-cycle pulse.

Top module: `adc_start_seq`

## Requirements
- R1: After reset the control register reads 0x00 and both `sar_track` and `sar_convert` are low. The register bits are [7] enable, [6] low-power track, [5] complete flag, [4] busy, [3] window flag, [2:0] start mode.
- R2: While enable is 0, no tracking or conversion takes place and every trigger is ignored. Writing enable to 0 during a conversion abandons it at once: busy falls, convert falls, and the complete flag is not set.
- R3: The start mode picks the trigger. 000 is a software write, 001 is timer 0 (`tmr_ovf[0]`), 010 is timer 2 (`tmr_ovf[2]`), 011 is timer 1 (`tmr_ovf[1]`), 100 is a rising pin edge, and 101 is timer 3 (`tmr_ovf[3]`). The two codes 11x start nothing, and a timer that is not selected has no effect.
- R4: With low-power track 0, `sar_track` is high whenever the block is enabled and idle. An accepted trigger starts the conversion directly. Busy (bit 4) and `sar_convert` stay high for CONV_CLKS SAR periods, which is 24 system cycles at the default of 12 with `sar_div`=1.
- R5: With low-power track 1 and a start mode other than 100, `sar_track` stays low while the block is idle. An accepted trigger first raises `sar_track` for exactly 3 SAR periods. The conversion then follows with no gap.
- R6: With low-power track 1 and start mode 100, `sar_track` follows the inverted, synchronised pin while the block is idle. The conversion starts with no timed window. A pin rise driven between edges shows busy after the third rising clock edge.
- R7: Writing busy = 1 starts a conversion only when the written start mode is 000. Writing busy = 0 starts nothing.
- R8: The complete flag is set in the cycle where busy falls at the end of a conversion. It stays set until software writes 0 to it.
- R9: A `win_hit` pulse sets the window flag. The flag stays set until software writes 0 to it.
- R10: Triggers that arrive while tracking or converting are ignored, so the running conversion keeps its length.
- R11: When a hardware set and a software clear of a flag land in the same cycle, the flag ends up set.
- R12: One SAR period lasts `sar_div`+1 system cycles. The divider restarts when a trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| sar_div | input | DIV_W | SAR clock divide value (period = value + 1) |
| tmr_ovf | input | 4 | Timer overflow pulses, bit i is timer i |
| cnv_pin | input | 1 | External convert-start pin, asynchronous |
| win_hit | input | 1 | Window-match pulse from the comparator |
| sar_track | output | 1 | Track level to the SAR core |
| sar_convert | output | 1 | Convert level to the SAR core |

## Verification
Each trigger source is exercised alone. For every timer mode the bench first pulses a wrong timer and then the right one, which separates correct timer-to-code mapping from any-pulse acceptance. Busy, track and convert lengths are measured under two divider values, which tells a timed window apart from a direct start and shows that the divider scales every period. Further patterns check the synchronisation delay and level-controlled tracking on the pin, retriggering and abort in mid-conversion, and flag clears that collide with hardware sets.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TRACK = 2'd1,
        PH_CONV  = 2'd2
    } phase_e;

    // start-mode codes; order is fixed by software
    localparam logic [2:0] SM_SOFT = 3'b000;
    localparam logic [2:0] SM_TMR0 = 3'b001;
    localparam logic [2:0] SM_TMR2 = 3'b010;
    localparam logic [2:0] SM_TMR1 = 3'b011;
    localparam logic [2:0] SM_PIN  = 3'b100;
    localparam logic [2:0] SM_TMR3 = 3'b101;

    // control register bit positions
    localparam int CTL_EN   = 7;
    localparam int CTL_TM   = 6;
    localparam int CTL_DONE = 5;
    localparam int CTL_BUSY = 4;
    localparam int CTL_WIN  = 3;

endpackage

// File: rtl/adc_sar_clkdiv.sv
module adc_sar_clkdiv #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q >= div);
        cnt_d = cnt_q + 1'b1;
        if (restart || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick || restart) |=> (cnt_q == '0)); // R12

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic [3:0] tmr_ovf,
    input  logic       pin,
    output logic       hw_trig,
    output logic       pin_lvl
);

    localparam int SH_W = SYNC_STAGES + 1;

    // synchroniser stages plus one history stage for edge detection
    logic [SH_W-1:0] sh_d, sh_q;
    logic            pin_rise;

    always_comb begin
        sh_d     = {sh_q[SH_W-2:0], pin};
        pin_lvl  = sh_q[SYNC_STAGES-1];
        pin_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
        case (mode)
            SM_TMR0: hw_trig = tmr_ovf[0];
            SM_TMR1: hw_trig = tmr_ovf[1];
            SM_TMR2: hw_trig = tmr_ovf[2];
            SM_TMR3: hw_trig = tmr_ovf[3];
            SM_PIN:  hw_trig = pin_rise;
            default: hw_trig = 1'b0;
        endcase
    end

    // reset high so a pin idling high gives no false edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> !pin_rise); // R6

endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
    import adc_seq_pkg::*;
#(
    parameter int CONV_CLKS   = 12,
    parameter int TRACK_CLKS  = 3,
    parameter int DIV_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic [DIV_W-1:0] sar_div,
    input  logic [3:0]       tmr_ovf,
    input  logic             cnv_pin,
    input  logic             win_hit,
    output logic             sar_track,
    output logic             sar_convert
);

    localparam int PH_MAX = (CONV_CLKS > TRACK_CLKS) ? CONV_CLKS : TRACK_CLKS;
    localparam int CNT_W  = $clog2(PH_MAX + 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CLKS - 1);
    localparam logic [CNT_W-1:0] TRK_LAST  = CNT_W'(TRACK_CLKS - 1);

    typedef struct packed {
        logic             en;
        logic             tmode;
        logic             done;
        logic             win;
        logic [2:0]       mode;
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t       d, q;
    logic       eff_en, eff_tm;
    logic [2:0] eff_mode;
    logic       sw_go, hw_trig, pin_lvl, tick, start_ok, conv_fin;

    adc_trig_sel #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (eff_mode),
        .tmr_ovf (tmr_ovf),
        .pin     (cnv_pin),
        .hw_trig (hw_trig),
        .pin_lvl (pin_lvl)
    );

    adc_sar_clkdiv #(
        .DIV_W (DIV_W)
    ) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_ok),
        .div     (sar_div),
        .tick    (tick)
    );

    always_comb begin
        d        = q;
        start_ok = 1'b0;
        conv_fin = 1'b0;
        eff_en   = wr_en ? wr_data[CTL_EN] : q.en;
        eff_tm   = wr_en ? wr_data[CTL_TM] : q.tmode;
        eff_mode = wr_en ? wr_data[2:0]    : q.mode;
        sw_go    = wr_en && wr_data[CTL_BUSY] && (wr_data[2:0] == SM_SOFT);

        if (wr_en) begin
            d.en    = wr_data[CTL_EN];
            d.tmode = wr_data[CTL_TM];
            d.mode  = wr_data[2:0];
        end

        if (!eff_en) begin
            d.phase = PH_IDLE;
            d.cnt   = '0;
        end else begin
            case (q.phase)
                PH_IDLE: begin
                    if (sw_go || hw_trig) begin
                        start_ok = 1'b1;
                        d.cnt    = '0;
                        d.phase  = (eff_tm && eff_mode != SM_PIN) ? PH_TRACK : PH_CONV;
                    end
                end
                PH_TRACK: begin
                    if (tick) begin
                        if (q.cnt == TRK_LAST) begin
                            d.phase = PH_CONV;
                            d.cnt   = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                PH_CONV: begin
                    if (tick) begin
                        if (q.cnt == CONV_LAST) begin
                            d.phase  = PH_IDLE;
                            d.cnt    = '0;
                            conv_fin = 1'b1;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    d.phase = PH_IDLE;
                    d.cnt   = '0;
                end
            endcase
        end

        // hardware set outranks a software clear
        d.done = conv_fin | (wr_en ? wr_data[CTL_DONE] : q.done);
        d.win  = win_hit  | (wr_en ? wr_data[CTL_WIN]  : q.win);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data     = {q.en, q.tmode, q.done, (q.phase != PH_IDLE), q.win, q.mode};
        sar_convert = (q.phase == PH_CONV);
        sar_track   = q.en && ((q.phase == PH_TRACK) ||
                      ((q.phase == PH_IDLE) && (!q.tmode || (q.mode == SM_PIN && !pin_lvl))));
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !q.en |-> (!sar_track && !sar_convert)); // R2
    AST_RSVD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE && q.mode[2:1] == 2'b11 && !wr_en) |=> !rd_data[CTL_BUSY]); // R3
    AST_TRACK_CONV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sar_track && sar_convert)); // R5
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sar_convert) && q.en) |-> q.done); // R8
    AST_WIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |=> q.win); // R11
    AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_CONV && !tick) |=> (q.phase == PH_CONV || !q.en)); // R10

endmodule

// File: tb/test_adc_start_seq.sv
`timescale 1ns/1ps
module test_adc_start_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [3:0] sar_div = 4'd1;
    logic [3:0] tmr_ovf = 4'h0;
    logic       cnv_pin = 1'b1;
    logic       win_hit = 1'b0;
    logic       sar_track, sar_convert;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    adc_start_seq i_adc_start_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .sar_div     (sar_div),
        .tmr_ovf     (tmr_ovf),
        .cnv_pin     (cnv_pin),
        .win_hit     (win_hit),
        .sar_track   (sar_track),
        .sar_convert (sar_convert)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse_tmr(input int idx);
        tmr_ovf[idx] = 1'b1;
        @(negedge clk);
        tmr_ovf = 4'h0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (rd_data[4] && n < 500) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic logic [2:0] mode_of(input int t);
        case (t)
            0: return 3'b001;
            1: return 3'b011;
            2: return 3'b010;
            default: return 3'b101;
        endcase
    endfunction

    task automatic t_reset();
        check("R1 reg", int'(rd_data), 0);
        check("R1 track", int'(sar_track), 0);
        check("R1 convert", int'(sar_convert), 0);
    endtask

    task automatic t_off();
        wr(8'h10);
        check("R2 sw start while off", int'(rd_data[4]), 0);
        tmr_ovf = 4'hF;
        @(negedge clk);
        tmr_ovf = 4'h0;
        check("R2 timers while off", int'(rd_data[4]), 0);
        check("R2 no track while off", int'(sar_track), 0);
    endtask

    task automatic t_soft();
        int n;
        sar_div = 4'd1;
        wr(8'h80);
        check("R4 idle track", int'(sar_track), 1);
        wr(8'h90);
        check("R4 convert up", int'(sar_convert), 1);
        check("R4 track down in conv", int'(sar_track), 0);
        busy_len(n);
        check("R4 R12 busy length div1", n, 24);
        check("R8 done set", int'(rd_data[5]), 1);
        wait_cyc(5);
        check("R8 done sticky", int'(rd_data[5]), 1);
        wr(8'h80);
        check("R8 done cleared", int'(rd_data[5]), 0);
    endtask

    task automatic t_write_rules();
        wr(8'h80);
        check("R7 busy write 0", int'(rd_data[4]), 0);
        wr(8'h81);
        wr(8'h91);
        check("R7 busy write in mode 001", int'(rd_data[4]), 0);
    endtask

    task automatic t_timers();
        int n;
        sar_div = 4'd0;
        for (int t = 0; t < 4; t++) begin
            wr({5'b10000, mode_of(t)});
            pulse_tmr((t + 1) % 4);
            check($sformatf("R3 wrong timer t%0d", t), int'(rd_data[4]), 0);
            pulse_tmr(t);
            check($sformatf("R3 right timer t%0d", t), int'(rd_data[4]), 1);
            busy_len(n);
            check($sformatf("R4 length t%0d", t), n, 12);
        end
    endtask

    task automatic t_reserved();
        for (int m = 6; m < 8; m++) begin
            wr(8'h80 | 8'(m));
            tmr_ovf = 4'hF;
            @(negedge clk);
            tmr_ovf = 4'h0;
            wr(8'h90 | 8'(m));
            check($sformatf("R3 reserved %0d", m), int'(rd_data[4]), 0);
        end
    endtask

    task automatic t_pin_direct();
        int n;
        sar_div = 4'd0;
        cnv_pin = 1'b1;
        wr(8'h84);
        cnv_pin = 1'b0;
        wait_cyc(4);
        check("R4 track mode0 pin low", int'(sar_track), 1);
        cnv_pin = 1'b1;
        wait_cyc(2);
        check("R3 pin rise not yet", int'(rd_data[4]), 0);
        wait_cyc(1);
        check("R3 pin rise start", int'(rd_data[4]), 1);
        busy_len(n);
        check("R3 pin conv length", n, 12);
    endtask

    task automatic t_lp_timed();
        int n;
        sar_div = 4'd2;
        wr(8'hC1);
        check("R5 idle no track", int'(sar_track), 0);
        pulse_tmr(0);
        n = 0;
        while (sar_track && n < 500) begin
            n++;
            @(negedge clk);
        end
        check("R5 track window", n, 9);
        check("R5 convert follows", int'(sar_convert), 1);
        n = 0;
        while (sar_convert && n < 500) begin
            n++;
            @(negedge clk);
        end
        check("R5 R12 convert length div2", n, 36);
    endtask

    task automatic t_lp_pin();
        int n;
        sar_div = 4'd0;
        cnv_pin = 1'b1;
        wr(8'hC4);
        wait_cyc(3);
        check("R6 pin high no track", int'(sar_track), 0);
        cnv_pin = 1'b0;
        wait_cyc(2);
        check("R6 pin low track", int'(sar_track), 1);
        check("R6 no busy on fall", int'(rd_data[4]), 0);
        cnv_pin = 1'b1;
        wait_cyc(2);
        check("R6 track ends", int'(sar_track), 0);
        check("R6 busy not yet", int'(rd_data[4]), 0);
        wait_cyc(1);
        check("R6 conv on rise", int'(sar_convert), 1);
        busy_len(n);
        check("R6 no timed window", n, 12);
    endtask

    task automatic t_retrig();
        int n;
        sar_div = 4'd0;
        wr(8'h81);
        pulse_tmr(0);
        n = 0;
        while (rd_data[4] && n < 500) begin
            n++;
            tmr_ovf[0] = (n == 3 || n == 7);
            @(negedge clk);
        end
        tmr_ovf = 4'h0;
        check("R10 retrigger ignored", n, 12);
    endtask

    task automatic t_abort();
        sar_div = 4'd0;
        wr(8'h81);
        pulse_tmr(0);
        wait_cyc(3);
        wr(8'h01);
        check("R2 abort busy", int'(rd_data[4]), 0);
        check("R2 abort convert", int'(sar_convert), 0);
        check("R2 abort no done", int'(rd_data[5]), 0);
    endtask

    task automatic t_win();
        wr(8'h80);
        win_hit = 1'b1;
        @(negedge clk);
        win_hit = 1'b0;
        check("R9 win set", int'(rd_data[3]), 1);
        wait_cyc(3);
        check("R9 win sticky", int'(rd_data[3]), 1);
        wr(8'h80);
        check("R9 win cleared", int'(rd_data[3]), 0);
    endtask

    task automatic t_prio();
        win_hit = 1'b1;
        @(negedge clk);
        win_hit = 1'b0;
        win_hit = 1'b1;
        wr(8'h80);
        win_hit = 1'b0;
        check("R11 win set beats clear", int'(rd_data[3]), 1);
        sar_div = 4'd0;
        wr(8'h90);
        wait_cyc(11);
        check("R11 last busy cycle", int'(rd_data[4]), 1);
        wr(8'h80);
        check("R11 busy ended", int'(rd_data[4]), 0);
        check("R11 done set beats clear", int'(rd_data[5]), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_soft();
        t_write_rules();
        t_timers();
        t_reserved();
        t_pin_direct();
        t_lp_timed();
        t_lp_pin();
        t_retrig();
        t_abort();
        t_win();
        t_prio();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule